// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Generator

This block drives one active-low system reset from three causes: a synchronous supply-good flag, a watchdog that a processor keeps alive with falling edges on a pin it shares with serial chip select, and the release delay that follows power-up. Every reset ends the same way. Once its cause has cleared, the output stays low for a fixed release interval. All times are counted in ticks of a 1 ms enable pulse, and every interval is a parameter, so the same RTL can run at full scale in silicon and at reduced scale on a bench.

A two-bit period code picks one of three watchdog timeouts or turns the watchdog off. The code is sampled each time the watchdog restarts. A restart happens on a falling edge of the watchdog input and on every reset release, so changing the code in the middle of a count does not shorten or stretch the current window. A two-bit cause output records what produced the most recent reset.

The controller is a four-state machine:
- ST_HOLD: supply low or power-up, reset asserted.
- ST_WAIT: the supply is good and the release delay is counting.
- ST_RUN: reset released and the watchdog is counting.
- ST_WDRST: a watchdog reset pulse is in progress.

Named transitions:
- HOLD→WAIT: supply_ok is high.
- WAIT→RUN: the delay has elapsed.
- WAIT→HOLD: the supply dropped.
- RUN→WDRST: the watchdog expired.
- RUN→HOLD: the supply dropped.
- WDRST→RUN: the delay has elapsed.
- WDRST→HOLD: the supply dropped.

Top module: `sup_rst_gen`

## Requirements
- R1: While rst_n is low, reset_n_out is 0 and cause_out is 01 (power-up).
- R2: One clock after supply_ok is sampled low, reset_n_out is 0. Each entry into the hold state from any other state sets cause_out to 10 (low supply).
- R3: reset_n_out rises only after supply_ok has stayed high for RELEASE_TICKS consecutive ticks. A drop during that wait restarts the full wait once the supply returns.
- R4: After power-up with supply_ok low, cause_out stays 01 until some other cause occurs.
- R5: Period code 00 gives WD_LONG_TICKS, 01 gives WD_MID_TICKS, 10 gives WD_SHORT_TICKS, and 11 disables expiry.
- R6: Only a high-to-low transition of wdi, seen after a two-stage synchronizer, restarts the watchdog count, and it does so exactly once. Rising edges have no effect, and a steady level high or low lets the count expire.
- R7: On expiry reset_n_out goes to 0 and cause_out becomes 11 (watchdog). Reset is then released after RELEASE_TICKS further ticks.
- R8: If supply_ok falls during a watchdog reset pulse, cause_out becomes 10, and release occurs RELEASE_TICKS ticks after the supply recovers.
- R9: A change of the period code takes effect only at the next watchdog restart (a falling edge or a reset release).
- R10: While reset is asserted the watchdog count is held at zero. It counts from zero after release, so expiry falls exactly one period after the release tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick_1ms | input | 1 | One-cycle time base enable |
| supply_ok | input | 1 | Synchronous supply-above-trip flag |
| wdi | input | 1 | Watchdog input shared with chip select |
| wd_code | input | 2 | Watchdog period code |
| reset_n_out | output | 1 | Active-low reset level |
| cause_out | output | 2 | Last reset cause: 01 power-up, 10 low supply, 11 watchdog |

## Verification
The bench builds the block with a release delay of 8 ticks and watchdog periods of 20, 12 and 6 ticks. The tick pulse comes every 8 clocks. At these values every timeout, including a supply drop inside a watchdog pulse and a mid-count code change, finishes within a few hundred ticks. Every expected reset edge and cause change is predicted as an exact tick number. That exactness separates a rising-edge kick, a delay that is not restarted and a code latched too early from the correct behaviour.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_RUN   = 2'd2,
        ST_WDRST = 2'd3
    } sup_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_PWRUP = 2'b01,
        CAUSE_LOWV  = 2'b10,
        CAUSE_WDOG  = 2'b11
    } cause_e;

    localparam logic [1:0] WDCODE_LONG  = 2'b00;
    localparam logic [1:0] WDCODE_MID   = 2'b01;
    localparam logic [1:0] WDCODE_SHORT = 2'b10;
    localparam logic [1:0] WDCODE_OFF   = 2'b11;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sup_wdi_edge.sv
module sup_wdi_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wdi,
    output logic kick
);
    // sh_q[SYNC_STAGES-1:0] is the synchronizer, sh_q[SYNC_STAGES] the previous synced value
    logic [SYNC_STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '1;
        end else begin
            sh_q <= {sh_q[SYNC_STAGES-1:0], wdi};
        end
    end

    assign kick = sh_q[SYNC_STAGES] & ~sh_q[SYNC_STAGES-1];

    // R6: one falling edge gives a single restart pulse
    p_single_kick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !kick);

endmodule

// File: rtl/sup_delay_cnt.sv
module sup_delay_cnt #(
    parameter int CNT_W         = 8,
    parameter int RELEASE_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic tick,
    output logic done
);
    localparam logic [CNT_W-1:0] REL_V = CNT_W'(RELEASE_TICKS);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en && tick && !done) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign done = (cnt_q == REL_V);

    // R3: the release counter never passes its limit
    p_delay_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= REL_V);

endmodule

// File: rtl/sup_wd_cnt.sv
module sup_wd_cnt
    import sup_rst_pkg::*;
#(
    parameter int CNT_W      = 11,
    parameter int LONG_TICKS = 1400,
    parameter int MID_TICKS  = 600,
    parameter int SHORT_TICKS = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       kick,
    input  logic       tick,
    input  logic [1:0] code,
    output logic       expire
);
    logic [CNT_W-1:0] lim_tab [4];
    logic [CNT_W-1:0] lim_q;
    logic [CNT_W-1:0] cnt_q;
    logic             off_q;
    logic             restart;

    // period table indexed by code; the off entry is never compared
    for (genvar g = 0; g < 4; g++) begin : g_lim
        if (g == int'(WDCODE_LONG)) begin : g_l
            assign lim_tab[g] = CNT_W'(LONG_TICKS);
        end else if (g == int'(WDCODE_MID)) begin : g_m
            assign lim_tab[g] = CNT_W'(MID_TICKS);
        end else if (g == int'(WDCODE_SHORT)) begin : g_s
            assign lim_tab[g] = CNT_W'(SHORT_TICKS);
        end else begin : g_o
            assign lim_tab[g] = '0;
        end
    end

    assign restart = !run || kick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= CNT_W'(LONG_TICKS);
            off_q <= 1'b0;
        end else if (restart) begin
            cnt_q <= '0;
            lim_q <= lim_tab[code];
            off_q <= (code == WDCODE_OFF);
        end else if (tick && !off_q && !expire) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign expire = run && !off_q && (cnt_q == lim_q);

    // R5: the count stays within the latched period
    p_count_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        off_q || (cnt_q <= lim_q));

    // R9: the latched period only changes at a restart
    p_limit_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !kick) |=> $stable(lim_q));

    // R10: the count is zero in the cycle after reset is still asserted
    p_cleared_in_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/sup_rst_gen.sv
module sup_rst_gen
    import sup_rst_pkg::*;
#(
    parameter int RELEASE_TICKS  = 200,
    parameter int WD_LONG_TICKS  = 1400,
    parameter int WD_MID_TICKS   = 600,
    parameter int WD_SHORT_TICKS = 200,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1ms,
    input  logic       supply_ok,
    input  logic       wdi,
    input  logic [1:0] wd_code,
    output logic       reset_n_out,
    output logic [1:0] cause_out
);
    localparam int WD_MAX = max_of(max_of(WD_LONG_TICKS, WD_MID_TICKS), WD_SHORT_TICKS);
    localparam int WD_W   = $clog2(WD_MAX + 1);
    localparam int DLY_W  = $clog2(RELEASE_TICKS + 1);

    sup_state_e state_q, state_d;
    cause_e     cause_q, cause_d;
    logic       kick;
    logic       wd_expire;
    logic       dly_done;
    logic       dly_en;
    logic       dly_clr;
    logic       wd_run;

    sup_wdi_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .wdi  (wdi),
        .kick (kick)
    );

    assign dly_en  = (state_q == ST_WAIT) || (state_q == ST_WDRST);
    assign dly_clr = !dly_en || (state_d != state_q);

    sup_delay_cnt #(.CNT_W(DLY_W), .RELEASE_TICKS(RELEASE_TICKS)) u_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (dly_clr),
        .en   (dly_en),
        .tick (tick_1ms),
        .done (dly_done)
    );

    assign wd_run = (state_q == ST_RUN);

    sup_wd_cnt #(
        .CNT_W      (WD_W),
        .LONG_TICKS (WD_LONG_TICKS),
        .MID_TICKS  (WD_MID_TICKS),
        .SHORT_TICKS(WD_SHORT_TICKS)
    ) u_wd (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (wd_run),
        .kick  (kick),
        .tick  (tick_1ms),
        .code  (wd_code),
        .expire(wd_expire)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            cause_q <= CAUSE_PWRUP;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cause_d = cause_q;
        unique case (state_q)
            ST_HOLD: begin
                if (supply_ok) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (!supply_ok) begin
                    state_d = ST_HOLD;
                    cause_d = CAUSE_LOWV;
                end else if (dly_done) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (!supply_ok) begin
                    state_d = ST_HOLD;
                    cause_d = CAUSE_LOWV;
                end else if (wd_expire) begin
                    state_d = ST_WDRST;
                    cause_d = CAUSE_WDOG;
                end
            end
            ST_WDRST: begin
                if (!supply_ok) begin
                    state_d = ST_HOLD;
                    cause_d = CAUSE_LOWV;
                end else if (dly_done) begin
                    state_d = ST_RUN;
                end
            end
            default: begin
                state_d = ST_HOLD;
            end
        endcase
    end

    // outputs
    always_comb begin
        reset_n_out = (state_q == ST_RUN);
        cause_out   = cause_q;
    end

    // R2: low supply forces reset on the next clock
    p_low_supply_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !reset_n_out);

    // R3: a release is always preceded by a good supply
    p_release_after_supply_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_n_out) |-> $past(supply_ok));

    // R7: a reset that starts while the supply is good is a watchdog reset
    p_wd_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(reset_n_out) && $past(supply_ok)) |-> (cause_out == 2'b11));

    // R1: power-up cause is reported straight after reset
    p_pwrup_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cause_out == 2'b01));

endmodule

// File: tb/sup_rst_gen_test.sv
module sup_rst_gen_test;

    typedef struct {
        int         tk;
        logic       rn;
        logic [1:0] cs;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick_1ms = 1'b0;
    logic       supply_ok;
    logic       wdi;
    logic [1:0] wd_code;
    logic       reset_n_out;
    logic [1:0] cause_out;

    int   tick_no = 0;
    int   div = 0;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   mon_on = 1'b0;
    logic       prev_rn;
    logic [1:0] prev_cs;
    exp_t exp_q[$];

    sup_rst_gen #(
        .RELEASE_TICKS (8),
        .WD_LONG_TICKS (20),
        .WD_MID_TICKS  (12),
        .WD_SHORT_TICKS(6),
        .SYNC_STAGES   (2)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_1ms   (tick_1ms),
        .supply_ok  (supply_ok),
        .wdi        (wdi),
        .wd_code    (wd_code),
        .reset_n_out(reset_n_out),
        .cause_out  (cause_out)
    );

    always #5 clk = ~clk;

    // tick every 8 clocks, driven away from the active edge
    always @(negedge clk) begin
        div      <= (div == 7) ? 0 : div + 1;
        tick_1ms <= (div == 7);
        if (div == 7) tick_no <= tick_no + 1;
    end

    task automatic sync_tick();
        do @(negedge clk); while (tick_1ms !== 1'b1);
    endtask

    task automatic wait_until(input int t);
        while (tick_no < t) sync_tick();
    endtask

    task automatic push(input int t, input logic rn, input logic [1:0] cs, input string req);
        exp_t e;
        e.tk = t; e.rn = rn; e.cs = cs; e.req = req;
        exp_q.push_back(e);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (mon_on && ((reset_n_out !== prev_rn) || (cause_out !== prev_cs))) begin
            n_vec++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected change at tick %0d: rn=%b cause=%b, expected no change",
                         tick_no, reset_n_out, cause_out);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.tk != tick_no || e.rn !== reset_n_out || e.cs !== cause_out) begin
                    n_bad++;
                    $display("FAIL %s: actual tick=%0d rn=%b cause=%b, expected tick=%0d rn=%b cause=%b",
                             e.req, tick_no, reset_n_out, cause_out, e.tk, e.rn, e.cs);
                end
            end
            prev_rn = reset_n_out;
            prev_cs = cause_out;
        end
    end

    // watchdog on the run itself
    initial begin
        repeat (30000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int t, tr, tw, r3, r4, d, e;
        rst_n = 1'b0; supply_ok = 1'b0; wdi = 1'b1; wd_code = 2'b10;
        repeat (3) @(negedge clk);
        // R1: reset state
        n_vec++;
        if (reset_n_out !== 1'b0 || cause_out !== 2'b01) begin
            n_bad++;
            $display("FAIL R1: actual rn=%b cause=%b, expected rn=0 cause=01", reset_n_out, cause_out);
        end
        prev_rn = reset_n_out; prev_cs = cause_out; mon_on = 1'b1;

        sync_tick(); rst_n = 1'b1; t = tick_no;
        // R4: supply low after power-up, no change expected
        wait_until(t + 5);
        supply_ok = 1'b1; t = tick_no;
        push(t + 8, 1'b1, 2'b01, "R3 power-up release / R4 cause kept");
        tr = t + 8;
        // R5 code 10 short period, R6 steady high, R7 pulse, R10 count from release
        push(tr + 6, 1'b0, 2'b11, "R5 short expiry R6 steady high R10");
        push(tr + 14, 1'b1, 2'b11, "R7 watchdog pulse length");
        tw = tr + 14;
        wait_until(tw + 4); wdi = 1'b0;          // falling edge restarts
        wait_until(tw + 8); wdi = 1'b1;          // rising edge ignored
        push(tw + 10, 1'b0, 2'b11, "R6 rising edge ignored");
        push(tw + 18, 1'b1, 2'b11, "R7 release after pulse");
        r3 = tw + 18;
        wait_until(r3 + 1); wdi = 1'b0;          // kick, then steady low
        wait_until(r3 + 3); wd_code = 2'b01;     // mid-count change
        push(r3 + 7, 1'b0, 2'b11, "R9 old period kept R6 steady low");
        push(r3 + 15, 1'b1, 2'b11, "R7 release");
        push(r3 + 27, 1'b0, 2'b11, "R5 mid period after restart R9");
        push(r3 + 35, 1'b1, 2'b11, "R7 release");
        wait_until(r3 + 30); wd_code = 2'b11;    // disabled from next release
        r4 = r3 + 35;
        d = r4 + 30;                             // R5 disabled: no change until d
        wait_until(d); supply_ok = 1'b0;
        push(d, 1'b0, 2'b10, "R2 supply drop R5 disabled");
        wait_until(d + 3); supply_ok = 1'b1;
        wait_until(d + 8); supply_ok = 1'b0;     // glitch inside release wait
        wait_until(d + 10); supply_ok = 1'b1;
        push(d + 18, 1'b1, 2'b10, "R3 delay restarted after glitch");
        e = d + 18;
        wait_until(e + 2); wdi = 1'b1;
        wait_until(e + 4); wd_code = 2'b00; wdi = 1'b0;
        push(e + 24, 1'b0, 2'b11, "R5 long period R9 taken at kick");
        wait_until(e + 27); supply_ok = 1'b0;
        push(e + 27, 1'b0, 2'b10, "R8 supply drop in watchdog pulse");
        wait_until(e + 30); supply_ok = 1'b1;
        push(e + 38, 1'b1, 2'b10, "R8 release after recovery");
        push(e + 58, 1'b0, 2'b11, "R10 long period from release");
        push(e + 66, 1'b1, 2'b11, "R7 release");
        wait_until(e + 66); wd_code = 2'b11;
        wait_until(e + 70);
        n_vec++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R7: actual %0d expected events left, expected 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule